// File: doc/BRIEF.md
# I2C Memory Slave with Pin-Selected Address

This block is the serial front end of a byte-addressed memory that sits on an I2C bus. It recovers START and STOP conditions from the oversampled bus lines, shifts bytes in and out most significant bit first, and drives the acknowledge bit. The address it answers to is chosen by a select pin: with the pin low it answers to a fixed 7-bit address, and with the pin high it answers to a programmable 7-bit address. That programmable address is a register inside the block, loaded whenever a write lands on a set memory location.

In a write transaction, the first byte after the address byte sets an internal 8-bit pointer. Each later byte goes out on the memory port as a single-cycle write strobe, and the pointer then steps by one. In a read transaction, the block fetches the byte at the pointer and sends it. It keeps fetching and sending as long as the master acknowledges, and lets go of the data line when the master does not. While the memory side reports that it is busy, the block does not acknowledge its address, so the master can poll it until the memory is ready. SDA is driven only low, through one enable output.

Top module: `i2c_addr_slave`

## Requirements
- R1: After reset, and after every STOP (SDA rising while SCL is high), the block is idle and `sda_drive_low` is 0.
- R2: With `addr_sel` = 0, an address byte whose upper seven bits equal 51h (A2h to write, A3h to read) is acknowledged, and any other address is not acknowledged.
- R3: With `addr_sel` = 1, the block matches the upper seven bits of the address byte against the programmable address register, whose reset value is 3Ch (byte 78h). The fixed address 51h is then not acknowledged.
- R4: A write data byte stored at pointer 9Fh also loads its bits 7:1 into the programmable address register.
- R5: After an address mismatch, the block acknowledges no byte and issues no memory write until the next START.
- R6: In a write, the byte after the address byte becomes the pointer. Each following byte is acknowledged and written to `mem_addr` = pointer, and the pointer then steps by one, wrapping from FFh to 00h.
- R7: In a read, bytes are sent MSB first, starting at the pointer. Each master ACK (SDA low in the ninth clock) advances the pointer and sends the next byte.
- R8: A master NACK (SDA high in the ninth clock) ends the read. SDA stays released until the next START.
- R9: While `mem_busy` is 1 when an address byte completes, the address is not acknowledged.
- R10: A repeated START at any point returns the block to receiving an address byte. The pointer keeps its value.
- R11: `sda_drive_low` is asserted only during an acknowledge the block gives or a data bit it sends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_sel | input | 1 | 0 selects the fixed address, 1 selects the programmable one |
| mem_busy | input | 1 | Memory busy with an internal write; the address is not acknowledged |
| mem_addr | output | 8 | Memory byte address for a read or a write |
| mem_wr_en | output | 1 | One-cycle write strobe |
| mem_wr_data | output | 8 | Write data |
| mem_rd_en | output | 1 | One-cycle read request; data is expected on the next clock |
| mem_rd_data | input | 8 | Read data from memory |

## Verification
Two functions can meet in the same transaction. A data byte written to location 9Fh rewrites the address register, and the address compare for the next transaction uses that register. The bench writes a new address with the select pin high and then issues a repeated START with no STOP in between. The new address must be acknowledged and the old one refused. The second pair is a master ACK and the memory fetch it starts: the pointer step and the read request come on the same rising SCL edge, and the fetched byte must be in place before the next falling edge. This is judged by reading a run of bytes across the FFh to 00h wrap and comparing each one with a bench-side copy of the memory.

// File: rtl/i2c_sl_pkg.sv
package i2c_sl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACKO, ST_TX, ST_ACKI, ST_IGN
  } st_t;
  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} kind_t;
endpackage

// File: rtl/i2c_sl_sync.sv
module i2c_sl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_sl_addr.sv
module i2c_sl_addr #(
  parameter logic [6:0] FIXED_ADDR = 7'h51,
  parameter logic [6:0] PROG_RST   = 7'h3C
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       addr_sel,
  input  logic       upd_en,
  input  logic [6:0] upd_val,
  input  logic [6:0] rx_addr,
  output logic       addr_hit
);
  logic       sel_q;
  logic [6:0] prog_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      prog_q <= PROG_RST;
    end else begin
      sel_q <= addr_sel;
      if (upd_en) prog_q <= upd_val;
    end
  end

  assign addr_hit = (rx_addr == (sel_q ? prog_q : FIXED_ADDR));
endmodule

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave
  import i2c_sl_pkg::*;
#(
  parameter logic [6:0] FIXED_ADDR  = 7'h51,
  parameter logic [6:0] PROG_RST    = 7'h3C,
  parameter logic [7:0] REG_LOC     = 8'h9F,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_drive_low,
  input  logic       addr_sel,
  input  logic       mem_busy,
  output logic [7:0] mem_addr,
  output logic       mem_wr_en,
  output logic [7:0] mem_wr_data,
  output logic       mem_rd_en,
  input  logic [7:0] mem_rd_data
);
  localparam int BW = 8;
  localparam int CW = $clog2(BW);
  localparam logic [CW-1:0] LAST_BIT = CW'(BW - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic addr_hit;
  st_t   state_q;
  kind_t kind_q;
  logic [CW-1:0] bitcnt_q;
  logic          byte_done_q, rw_q, got_ack_q, rd_pend_q, sda_low_q;
  logic [BW-1:0] sh_q, tx_q, ptr_q;
  logic [7:0]    addr_q, wdata_q;
  logic          we_q, re_q;

  i2c_sl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_sl_addr #(.FIXED_ADDR(FIXED_ADDR), .PROG_RST(PROG_RST)) u_addr (
    .clk(clk), .rst(rst), .addr_sel(addr_sel),
    .upd_en(we_q && (addr_q == REG_LOC)), .upd_val(wdata_q[7:1]),
    .rx_addr(sh_q[7:1]), .addr_hit(addr_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      kind_q      <= K_ADDR;
      bitcnt_q    <= '0;
      byte_done_q <= 1'b0;
      rw_q        <= 1'b0;
      got_ack_q   <= 1'b0;
      rd_pend_q   <= 1'b0;
      sda_low_q   <= 1'b0;
      sh_q        <= '0;
      tx_q        <= '0;
      ptr_q       <= '0;
      addr_q      <= '0;
      wdata_q     <= '0;
      we_q        <= 1'b0;
      re_q        <= 1'b0;
    end else begin
      we_q      <= 1'b0;
      re_q      <= 1'b0;
      rd_pend_q <= re_q;
      if (rd_pend_q) tx_q <= mem_rd_data;
      if (start_det) begin
        state_q     <= ST_RX;
        kind_q      <= K_ADDR;
        bitcnt_q    <= '0;
        byte_done_q <= 1'b0;
        sda_low_q   <= 1'b0;
      end else if (stop_det) begin
        state_q   <= ST_IDLE;
        sda_low_q <= 1'b0;
      end else begin
        case (state_q)
          ST_RX: begin
            if (scl_rise) begin
              sh_q     <= {sh_q[BW-2:0], sda_s};
              bitcnt_q <= bitcnt_q + 1'b1;
              if (bitcnt_q == LAST_BIT) byte_done_q <= 1'b1;
            end else if (scl_fall && byte_done_q) begin
              byte_done_q <= 1'b0;
              bitcnt_q    <= '0;
              case (kind_q)
                K_ADDR: begin
                  if (addr_hit && !mem_busy) begin
                    rw_q      <= sh_q[0];
                    sda_low_q <= 1'b1;
                    state_q   <= ST_ACKO;
                    if (sh_q[0]) begin
                      re_q   <= 1'b1;
                      addr_q <= ptr_q;
                    end
                  end else begin
                    state_q <= ST_IGN;
                  end
                end
                K_PTR: begin
                  ptr_q     <= sh_q;
                  sda_low_q <= 1'b1;
                  state_q   <= ST_ACKO;
                end
                default: begin
                  we_q      <= 1'b1;
                  addr_q    <= ptr_q;
                  wdata_q   <= sh_q;
                  ptr_q     <= ptr_q + 1'b1;
                  sda_low_q <= 1'b1;
                  state_q   <= ST_ACKO;
                end
              endcase
            end
          end
          ST_ACKO: begin
            if (scl_fall) begin
              if (kind_q == K_ADDR && rw_q) begin
                sda_low_q <= ~tx_q[BW-1];
                bitcnt_q  <= '0;
                state_q   <= ST_TX;
              end else begin
                sda_low_q <= 1'b0;
                state_q   <= ST_RX;
                kind_q    <= (kind_q == K_ADDR) ? K_PTR : K_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt_q == LAST_BIT) begin
                sda_low_q <= 1'b0;
                got_ack_q <= 1'b0;
                state_q   <= ST_ACKI;
              end else begin
                sda_low_q <= ~tx_q[BW-2];
                tx_q      <= {tx_q[BW-2:0], 1'b0};
                bitcnt_q  <= bitcnt_q + 1'b1;
              end
            end
          end
          ST_ACKI: begin
            if (scl_rise) begin
              if (sda_s) begin
                state_q <= ST_IGN;
              end else begin
                got_ack_q <= 1'b1;
                ptr_q     <= ptr_q + 1'b1;
                re_q      <= 1'b1;
                addr_q    <= ptr_q + 1'b1;
              end
            end else if (scl_fall && got_ack_q) begin
              sda_low_q <= ~tx_q[BW-1];
              bitcnt_q  <= '0;
              state_q   <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_drive_low = sda_low_q;
  assign mem_addr      = addr_q;
  assign mem_wr_en     = we_q;
  assign mem_wr_data   = wdata_q;
  assign mem_rd_en     = re_q;
endmodule

// File: rtl/i2c_sl_chk.sv
module i2c_sl_chk
  import i2c_sl_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input st_t        st,
  input kind_t      kind,
  input logic       sda_low,
  input logic       start_det,
  input logic       stop_det,
  input logic       mem_busy,
  input logic       mem_wr_en,
  input logic       mem_rd_en,
  input logic [7:0] mem_addr,
  input logic [7:0] ptr
);
  a_r1_stop_idle: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (st == ST_IDLE && !sda_low));

  a_r10_start_addr: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (st == ST_RX && kind == K_ADDR && !sda_low));

  a_r11_drive_window: assert property (@(posedge clk) disable iff (rst)
    sda_low |-> (st == ST_ACKO || st == ST_TX));

  a_r9_busy_nack: assert property (@(posedge clk) disable iff (rst)
    ($rose(st == ST_ACKO) && kind == K_ADDR) |-> !$past(mem_busy));

  a_r6_ptr_step: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> (ptr == mem_addr + 8'd1));

  a_r7_port_excl: assert property (@(posedge clk) disable iff (rst)
    !(mem_wr_en && mem_rd_en));

  a_r5_ign_silent: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IGN && !start_det) |=> !mem_wr_en);
endmodule

bind i2c_addr_slave i2c_sl_chk u_chk (
  .clk(clk), .rst(rst), .st(state_q), .kind(kind_q), .sda_low(sda_low_q),
  .start_det(start_det), .stop_det(stop_det), .mem_busy(mem_busy),
  .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .ptr(ptr_q)
);

// File: tb/test_i2c_addr_slave.sv
module test_i2c_addr_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic addr_sel = 1'b0, mem_busy = 1'b0;
  logic sda_drive_low, mem_wr_en, mem_rd_en;
  logic [7:0] mem_addr, mem_wr_data, mem_rd_data;
  logic sda_line;
  logic [7:0] mem [256];
  logic [15:0] exp_q[$];
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_drive_low;

  i2c_addr_slave i_i2c_addr_slave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_drive_low(sda_drive_low), .addr_sel(addr_sel), .mem_busy(mem_busy),
    .mem_addr(mem_addr), .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data),
    .mem_rd_en(mem_rd_en), .mem_rd_data(mem_rd_data)
  );

  always_ff @(posedge clk) begin
    if (mem_wr_en) mem[mem_addr] <= mem_wr_data;
    if (mem_rd_en) mem_rd_data <= mem[mem_addr];
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops expected writes as the design issues them
  always @(negedge clk) begin
    if (!rst && mem_wr_en) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R5: actual write %0h@%0h expected none", mem_wr_data, mem_addr);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        if ({mem_addr, mem_wr_data} !== e) begin
          errors++;
          $display("FAIL R6: actual %0h expected %0h", {mem_addr, mem_wr_data}, e);
        end
      end
    end
  end

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(); scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q(); scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(); scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic bit_io(input logic b, output logic s);
    sda_m = b; wait_q(); scl_m = 1'b1; wait_q();
    s = sda_line; wait_q(); scl_m = 1'b0; wait_q();
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(v[i], s);
    bit_io(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic master_ack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s);
      v[i] = s;
    end
    bit_io(~master_ack, s);
  endtask

  task automatic push_wr(input logic [7:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack, s;
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(sda_drive_low == 1'b0, "R1 reset", sda_drive_low, 0);
    chk(mem_wr_en == 1'b0, "R1 reset we", mem_wr_en, 0);

    // R2/R6: fixed address write of two bytes
    bus_start();
    wr_byte(8'hA2, ack); chk(ack, "R2 fixed ack", ack, 1);
    wr_byte(8'h10, ack); chk(ack, "R6 ptr ack", ack, 1);
    push_wr(8'h10, 8'hAA); wr_byte(8'hAA, ack); chk(ack, "R6 data ack", ack, 1);
    push_wr(8'h11, 8'h55); wr_byte(8'h55, ack); chk(ack, "R6 data ack2", ack, 1);
    bus_stop();
    repeat (4) @(negedge clk);
    chk(sda_drive_low == 1'b0, "R1 stop release", sda_drive_low, 0);

    // R2/R5: mismatch is ignored until START
    bus_start();
    wr_byte(8'h78, ack); chk(!ack, "R2 mismatch nack", ack, 0);
    wr_byte(8'h20, ack); chk(!ack, "R5 ignore ptr", ack, 0);
    wr_byte(8'h99, ack); chk(!ack, "R5 ignore data", ack, 0);
    bus_stop();

    // R10/R7/R8: pointer set then repeated START into a read
    bus_start();
    wr_byte(8'hA2, ack); wr_byte(8'h10, ack);
    bus_start();
    wr_byte(8'hA3, ack); chk(ack, "R10 restart ack", ack, 1);
    rd_byte(1'b1, v); chk(v == 8'hAA, "R7 read first", v, 8'hAA);
    rd_byte(1'b0, v); chk(v == 8'h55, "R7 read next", v, 8'h55);
    bit_io(1'b1, s); chk(s == 1'b1, "R8 released after nack", s, 1);
    bit_io(1'b1, s); chk(s == 1'b1, "R8 released bit2", s, 1);
    bus_stop();

    // R9: busy memory
    mem_busy = 1'b1;
    bus_start();
    wr_byte(8'hA2, ack); chk(!ack, "R9 busy nack", ack, 0);
    bus_stop();
    mem_busy = 1'b0;
    bus_start();
    wr_byte(8'hA2, ack); chk(ack, "R9 ready ack", ack, 1);
    bus_stop();

    // R3: programmable address at its reset value
    addr_sel = 1'b1;
    bus_start();
    wr_byte(8'hA2, ack); chk(!ack, "R3 fixed refused", ack, 0);
    bus_start();
    wr_byte(8'h78, ack); chk(ack, "R3 reset prog ack", ack, 1);
    // R4: rewrite the address, then repeated START with the new one
    wr_byte(8'h9F, ack);
    push_wr(8'h9F, 8'hCC); wr_byte(8'hCC, ack);
    bus_start();
    wr_byte(8'h78, ack); chk(!ack, "R4 old refused", ack, 0);
    bus_start();
    wr_byte(8'hCC, ack); chk(ack, "R4 new ack", ack, 1);
    // R6: pointer wraps FFh -> 00h
    wr_byte(8'hFF, ack);
    push_wr(8'hFF, 8'h01); wr_byte(8'h01, ack);
    push_wr(8'h00, 8'h02); wr_byte(8'h02, ack);
    bus_start();
    wr_byte(8'hCC, ack); wr_byte(8'hFF, ack);
    bus_start();
    wr_byte(8'hCD, ack); chk(ack, "R7 read ack", ack, 1);
    rd_byte(1'b1, v); chk(v == 8'h01, "R7 read FF", v, 8'h01);
    rd_byte(1'b0, v); chk(v == 8'h02, "R6 wrap read 00", v, 8'h02);
    bus_stop();
    addr_sel = 1'b0;
    bus_start();
    wr_byte(8'hA2, ack); chk(ack, "R2 fixed again", ack, 1);
    bus_stop();

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all writes seen", exp_q.size(), 0);
    chk(sda_drive_low == 1'b0, "R11 idle release", sda_drive_low, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule